// File: doc/BRIEF.md
# Cache Miss Type Classifier

This monitor watches the line addresses presented to a direct-mapped cache of `LINES` entries. It labels every access as a hit, a compulsory miss, a capacity miss or a conflict miss. The label appears on its output one cycle after the access. It keeps its own copy of the direct-mapped tag array. It also keeps a shadow fully-associative cache with the same number of lines and least-recently-used replacement, and one "touched" bit for every line in a bounded address space of `2**ADDR_W` lines.

A miss on a line that has never been touched since reset is compulsory. Any other miss is checked against the shadow cache. If the shadow cache also misses, the miss is a capacity miss. If the shadow cache hits, the miss comes from the direct mapping alone and is a conflict miss. A saturating counter for each of the four labels gives running totals. Performance monitors and design-space studies can use the block to split the misses of an access trace by cause.

Top module: `miss_classifier`

## Requirements
- R1: After reset `cls_valid` is 0 and all four counters are 0. No line counts as touched, and both the direct-mapped copy and the shadow cache are empty.
- R2: `cls_valid` is 1 in exactly the cycle after a cycle with `acc_valid` high, and `cls_code` then labels that access. Cycles with `acc_valid` low change no state.
- R3: The label encoding is 0 for a hit, 1 for compulsory, 2 for capacity and 3 for conflict. A hit means the direct-mapped entry at index `acc_line mod LINES` holds the same line address. `LINES` is a power of two.
- R4: A miss on a line not referenced since reset is labelled compulsory, whatever the shadow cache holds. The line address range 0 to `2**ADDR_W-1` is fully tracked, including the top address.
- R5: A miss on a line referenced before that also misses in the shadow fully-associative LRU cache is labelled capacity.
- R6: A miss on a line referenced before that hits in the shadow cache is labelled conflict.
- R7: Every access updates the LRU order of the shadow cache and makes the accessed line most recent, including accesses that hit in the direct-mapped copy. A shadow miss replaces the least recently used line once the shadow cache is full.
- R8: On each labelled access, the counter for its label (`cnt_hit`, `cnt_comp`, `cnt_cap`, `cnt_conf`) rises by one. A counter holds at `2**CNT_W-1` and does not wrap.
- R9: A direct-mapped miss loads the accessed line into the direct-mapped copy, replacing the line that shared its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_line | input | ADDR_W | Line address of the access |
| cls_valid | output | 1 | `cls_code` is valid |
| cls_code | output | 2 | Label: 0 hit, 1 compulsory, 2 capacity, 3 conflict |
| cnt_hit | output | CNT_W | Saturating count of hits |
| cnt_comp | output | CNT_W | Saturating count of compulsory misses |
| cnt_cap | output | CNT_W | Saturating count of capacity misses |
| cnt_conf | output | CNT_W | Saturating count of conflict misses |

## Verification
The first pattern is a cyclic sweep over five lines mapped onto four entries. It produces all four labels, and it separates a repeat miss that the shadow cache also misses from one that the shadow cache holds. A second trace touches a line as a direct-mapped hit just before pressure arrives. The later labels then show whether hits refresh the LRU order: if they do not, a capacity miss becomes a conflict miss. Further directed cases cover a long run of hits that drives a narrow counter into saturation, a first reference to the top address, idle cycles between accesses, and a reset that forgets every touched line.

// File: rtl/miss_classifier.sv
module miss_classifier #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_line,
  output logic              cls_valid,
  output logic [1:0]        cls_code,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_comp,
  output logic [CNT_W-1:0]  cnt_cap,
  output logic [CNT_W-1:0]  cnt_conf
);
  localparam int IDX_W = $clog2(LINES);
  localparam int SPACE = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

  logic [SPACE-1:0]  seen;
  logic [LINES-1:0]  dm_v;
  logic [ADDR_W-1:0] dm_tag [LINES];
  logic [LINES-1:0]  fa_v;
  logic [ADDR_W-1:0] fa_tag [LINES];
  logic [IDX_W-1:0]  fa_age [LINES];
  logic [CNT_W-1:0]  cnt [4];

  logic [IDX_W-1:0] idx;
  logic             dm_hit, fa_hit, any_free;
  logic [IDX_W-1:0] hit_way, free_way, lru_way, tgt_way;
  logic [IDX_W:0]   thr;
  logic [1:0]       code_now;
  logic [LINES-1:0] mru_vec;

  assign idx    = acc_line[IDX_W-1:0];
  assign dm_hit = dm_v[idx] && (dm_tag[idx] == acc_line);

  always_comb begin
    fa_hit   = 1'b0;
    any_free = 1'b0;
    hit_way  = '0;
    free_way = '0;
    lru_way  = '0;
    for (int w = LINES - 1; w >= 0; w--) begin
      if (fa_v[w] && fa_tag[w] == acc_line) begin
        fa_hit  = 1'b1;
        hit_way = IDX_W'(w);
      end
      if (!fa_v[w]) begin
        any_free = 1'b1;
        free_way = IDX_W'(w);
      end
      if (fa_v[w] && fa_age[w] == OLDEST) lru_way = IDX_W'(w);
    end
    tgt_way = fa_hit ? hit_way : (any_free ? free_way : lru_way);
    thr     = fa_hit ? {1'b0, fa_age[hit_way]} :
              (any_free ? (IDX_W+1)'(LINES) : (IDX_W+1)'(LINES - 1));
  end

  assign code_now = dm_hit ? 2'd0 : (!seen[acc_line] ? 2'd1 : (fa_hit ? 2'd3 : 2'd2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= '0;
      dm_v      <= '0;
      fa_v      <= '0;
      cls_valid <= 1'b0;
      cls_code  <= 2'd0;
      for (int w = 0; w < LINES; w++) begin
        dm_tag[w] <= '0;
        fa_tag[w] <= '0;
        fa_age[w] <= '0;
      end
      for (int k = 0; k < 4; k++) cnt[k] <= '0;
    end else begin
      cls_valid <= acc_valid;
      if (acc_valid) begin
        cls_code       <= code_now;
        seen[acc_line] <= 1'b1;
        if (!dm_hit) begin
          dm_v[idx]   <= 1'b1;
          dm_tag[idx] <= acc_line;
        end
        for (int w = 0; w < LINES; w++) begin
          if (IDX_W'(w) == tgt_way) begin
            fa_v[w]   <= 1'b1;
            fa_tag[w] <= acc_line;
            fa_age[w] <= '0;
          end else if (fa_v[w] && {1'b0, fa_age[w]} < thr) begin
            fa_age[w] <= fa_age[w] + 1'b1;
          end
        end
        if (cnt[code_now] != CMAX) cnt[code_now] <= cnt[code_now] + 1'b1;
      end
    end
  end

  assign cnt_hit  = cnt[0];
  assign cnt_comp = cnt[1];
  assign cnt_cap  = cnt[2];
  assign cnt_conf = cnt[3];

  always_comb
    for (int w = 0; w < LINES; w++) mru_vec[w] = fa_v[w] && (fa_age[w] == '0);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> cls_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !cls_valid);
  // R7
  single_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mru_vec));
  // R7
  accessed_is_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> $countones(mru_vec) == 1);
  // R8
  hit_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_code == 2'd0 && $past(cnt_hit) != CMAX) |-> cnt_hit == $past(cnt_hit) + 1'b1);
  // R8
  conf_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_conf) == CMAX |-> cnt_conf == CMAX);
  // R2
  idle_counts_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_valid |-> ($stable(cnt_hit) && $stable(cnt_comp) && $stable(cnt_cap) && $stable(cnt_conf)));
endmodule

// File: tb/test_miss_classifier.sv
module test_miss_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;
  localparam int ADDR_W = 6;
  localparam int CNT_W = 4;
  localparam int NV = 11;
  localparam int VLINE [NV] = '{0, 1, 2, 3, 4, 1, 2, 3, 0, 4, 0};
  localparam int VCODE [NV] = '{1, 1, 1, 1, 1, 0, 0, 0, 2, 2, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_line = '0;
  logic cls_valid;
  logic [1:0] cls_code;
  logic [CNT_W-1:0] cnt_hit, cnt_comp, cnt_cap, cnt_conf;
  int checks = 0;
  int fails = 0;

  miss_classifier #(.LINES(LINES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_miss_classifier (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
    .cls_valid(cls_valid), .cls_code(cls_code), .cnt_hit(cnt_hit),
    .cnt_comp(cnt_comp), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input int line, input int code, input string req);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_line  = ADDR_W'(line);
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, int'(cls_valid), 1);
    check(req, int'(cls_code), code);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic counts(input string req, input int h, input int c, input int p, input int f);
    check({req, " hit"}, int'(cnt_hit), h);
    check({req, " comp"}, int'(cnt_comp), c);
    check({req, " cap"}, int'(cnt_cap), p);
    check({req, " conf"}, int'(cnt_conf), f);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(cls_valid), 0);
    counts("R1", 0, 0, 0, 0);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R9: cyclic sweep over five lines
    for (int v = 0; v < NV; v++) access(VLINE[v], VCODE[v], "R3 R4 R5 R6 R9 sweep");
    counts("R8 sweep", 3, 5, 2, 1);

    // R2 idle cycles: no valid, no state change
    repeat (3) begin
      @(negedge clk);
      check("R2 idle valid", int'(cls_valid), 0);
    end
    counts("R2 idle", 3, 5, 2, 1);
    access(0, 0, "R2 idle kept line 0");

    // R1 reset forgets touched lines
    do_reset();
    counts("R1 after reset", 0, 0, 0, 0);
    access(0, 1, "R1 line 0 compulsory again");

    // R7 direct-mapped hit refreshes LRU order
    access(1, 1, "R7");
    access(2, 1, "R7");
    access(3, 1, "R7");
    access(0, 0, "R7 hit refresh");
    access(5, 1, "R7");
    access(1, 2, "R7 refreshed line kept, capacity");
    access(0, 0, "R9 untouched index");
    access(4, 1, "R4");
    access(0, 3, "R6 conflict");

    // R4 top address first touch, then hit
    access(63, 1, "R4 top address");
    access(63, 0, "R3 top address hit");

    // R8 saturation
    do_reset();
    access(0, 1, "R8");
    for (int k = 0; k < 20; k++) access(0, 0, "R8 hits");
    counts("R8 saturate", 15, 1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule